// File: doc/BRIEF.md
# Tamper Response and Event Logger

This block watches a set of external tamper input pins. Each pin can be enabled as a tamper source on its own. When an enabled pin is detected, the block raises erase strobes toward three places: the cipher key store, the memory scrambling keys and the local backup register file. It then queues an entry in a small event log that holds the pin index and the value of a free-running seconds counter. A sticky status bit, together with a mask of the pins that fired, drives an interrupt until software clears it.

The block also holds the backup register file, which software can lock against reads, against writes, or both. Software reaches all configuration, status, log and backup storage through a flat word-addressed register port. Register reads are combinational. Writes take effect at the clock edge.

Register layout (5-bit word address):
- 0 control: bits [NPIN-1:0] select the source pins; bit 24 enables cipher key wiping; bit 25 enables backup wiping; bit 26 locks backup writes; bit 27 locks backup reads.
- 1 status: bit 0 is the sticky tamper flag; bit 1 is log overflow; bits [7:4] are the log fill level; bits [8+NPIN-1:8] are the pin source mask. Writing a word with bit 0 set clears the flag, the mask and the overflow bit.
- 2 log time: the timestamp of the oldest log entry, or zero when the log is empty.
- 3 log source: bit 31 is set when an entry is present, and bits [2:0] give its pin index. Any write to this address removes the oldest entry.
- 16 to 16+NBKP-1: the backup registers.

Top module: `tamper_guard`

## Requirements
- R1: Each pin passes through two synchronizer flops. A detection needs the enabled, synchronized pin to be high for two consecutive cycles, and a held pin fires only once until it goes low again. A pin that is high for a single clock period, or that is not enabled, causes no event.
- R2: `key_erase` is a one-cycle pulse in the cycle after detection, issued only when bit 24 of the control register is set.
- R3: `scramble_erase` is a one-cycle pulse in the cycle after every detection, whatever the control settings.
- R4: When bit 25 of the control register is set, a detection pulses `backup_erase` and clears every backup register, and the registers read zero from that cycle onward.
- R5: Every detection adds one log entry for each pin that fired. The entry holds the seconds counter value sampled at detection and the pin index.
- R6: Pins that fire in the same cycle are logged one entry per cycle, in ascending pin-index order.
- R7: A detection sets the sticky flag and ORs the firing pins into the source mask. `tamper_irq` follows the flag. A status write with bit 0 set clears the flag and the mask, and a new detection wins over a clear in the same cycle.
- R8: While the read lock (bit 27) is set, backup register reads return zero.
- R9: While the write lock (bit 26) is set, writes to the backup registers are ignored.
- R10: The log holds LOGD (4) entries. A push into a full log discards the oldest entry and sets the overflow bit, which is cleared together with the sticky flag.
- R11: A write to address 3 removes the oldest entry. When the log is empty, the source word reads with bit 31 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_pin | input | NPIN | Asynchronous tamper inputs, active high |
| sec_count | input | TSW | Free-running seconds counter |
| reg_addr | input | 5 | Register word address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| key_erase | output | 1 | Cipher key wipe strobe |
| scramble_erase | output | 1 | Scrambling key wipe strobe |
| backup_erase | output | 1 | Backup register wipe strobe |
| tamper_irq | output | 1 | Level interrupt, high while the sticky flag is set |

## Verification
The assertions assume that the tamper pins can change at any time, but that `sec_count` and the register port change only between clock edges. They also assume software does not pop the log in the same cycle as a detection it is checking. The stimulus drives every input on the falling edge. It holds the seconds counter steady while an event drains into the log, so that all entries of one batch carry the same timestamp. It releases all pins and waits for them to re-arm before each new scenario, which keeps a pin from staying high across a change of the enable mask.

// File: rtl/tamper_guard.sv
module tamper_guard #(
  parameter int NPIN = 8,
  parameter int NBKP = 8,
  parameter int TSW  = 32,
  parameter int LOGD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] tamper_pin,
  input  logic [TSW-1:0]  sec_count,
  input  logic [4:0]      reg_addr,
  input  logic            reg_we,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            key_erase,
  output logic            scramble_erase,
  output logic            backup_erase,
  output logic            tamper_irq
);
  localparam int IW = $clog2(NPIN);
  localparam int PW = $clog2(LOGD);
  localparam int CW = $clog2(LOGD + 1);
  localparam int BW = $clog2(NBKP);
  localparam logic [4:0] A_CTRL = 5'd0;
  localparam logic [4:0] A_STAT = 5'd1;
  localparam logic [4:0] A_TIME = 5'd2;
  localparam logic [4:0] A_SRC  = 5'd3;
  localparam logic [4:0] A_BKP  = 5'd16;

  logic [NPIN-1:0] s1, s2, s3, seen, hit, pend, src, pin_en;
  logic            key_en, bkp_en, wlock, rlock, sticky, ovf;
  logic [31:0]     bkp [NBKP];
  logic [TSW-1:0]  ts_hold;
  logic [TSW-1:0]  log_ts [LOGD];
  logic [IW-1:0]   log_id [LOGD];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   cnt;
  logic [IW-1:0]   pick_idx;
  logic [4:0]      boff;
  logic            any_hit, push, pop, clr, full, in_bkp;

  assign hit     = pin_en & s2 & s3 & ~seen;
  assign any_hit = |hit;
  assign push    = |pend;
  assign full    = (cnt == CW'(LOGD));
  assign pop     = reg_we && (reg_addr == A_SRC) && (cnt != '0);
  assign clr     = reg_we && (reg_addr == A_STAT) && reg_wdata[0];
  assign tamper_irq = sticky;
  assign boff    = reg_addr - A_BKP;
  assign in_bkp  = (reg_addr >= A_BKP) && (reg_addr < A_BKP + 5'(NBKP));

  always_comb begin
    pick_idx = '0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (pend[i]) pick_idx = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0; seen <= '0;
    end else begin
      s1 <= tamper_pin;
      s2 <= s1;
      s3 <= s2;
      seen <= pin_en & s2 & s3;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_erase <= 1'b0; scramble_erase <= 1'b0; backup_erase <= 1'b0;
    end else begin
      key_erase      <= any_hit & key_en;
      scramble_erase <= any_hit;
      backup_erase   <= any_hit & bkp_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_en <= '0; key_en <= 1'b0; bkp_en <= 1'b0; wlock <= 1'b0; rlock <= 1'b0;
    end else if (reg_we && reg_addr == A_CTRL) begin
      pin_en <= reg_wdata[NPIN-1:0];
      key_en <= reg_wdata[24];
      bkp_en <= reg_wdata[25];
      wlock  <= reg_wdata[26];
      rlock  <= reg_wdata[27];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= 1'b0; src <= '0;
    end else begin
      sticky <= any_hit | (sticky & ~clr);
      src    <= hit | (clr ? '0 : src);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBKP; i++) bkp[i] <= '0;
    end else begin
      for (int i = 0; i < NBKP; i++) begin
        if (any_hit && bkp_en) bkp[i] <= '0;
        else if (reg_we && !wlock && reg_addr == A_BKP + 5'(i)) bkp[i] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; ts_hold <= '0;
    end else begin
      pend <= (pend & ~(NPIN'(1) << pick_idx)) | hit;
      if (any_hit) ts_hold <= sec_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; ovf <= 1'b0;
      for (int i = 0; i < LOGD; i++) begin
        log_ts[i] <= '0;
        log_id[i] <= '0;
      end
    end else begin
      if (push) begin
        log_ts[wr_ptr] <= ts_hold;
        log_id[wr_ptr] <= pick_idx;
        wr_ptr <= wr_ptr + 1'b1;
      end
      if (push && !pop && full) begin
        rd_ptr <= rd_ptr + 1'b1;
        ovf <= 1'b1;
      end else begin
        if (pop) rd_ptr <= rd_ptr + 1'b1;
        if (clr) ovf <= 1'b0;
      end
      if (push && !pop && !full) cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[NPIN-1:0] = pin_en;
        reg_rdata[27:24] = {rlock, wlock, bkp_en, key_en};
      end
      A_STAT: begin
        reg_rdata[0] = sticky;
        reg_rdata[1] = ovf;
        reg_rdata[4 +: CW] = cnt;
        reg_rdata[8 +: NPIN] = src;
      end
      A_TIME: if (cnt != '0) reg_rdata[TSW-1:0] = log_ts[rd_ptr];
      A_SRC: if (cnt != '0) begin
        reg_rdata[31] = 1'b1;
        reg_rdata[IW-1:0] = log_id[rd_ptr];
      end
      default: if (in_bkp && !rlock) reg_rdata = bkp[boff[BW-1:0]];
    endcase
  end

  logic [31:0] bkp_any;
  always_comb begin
    bkp_any = '0;
    for (int i = 0; i < NBKP; i++) bkp_any = bkp_any | bkp[i];
  end

  assert_key_needs_scramble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    key_erase |-> scramble_erase);
  assert_backup_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    backup_erase |-> (bkp_any == '0));
  assert_irq_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    scramble_erase |-> tamper_irq);
  assert_log_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LOGD));
  assert_ovf_only_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> full);
  assert_pop_drains_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: tb/tamper_guard_tb.sv
`timescale 1ns/1ps
module tamper_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tamper_pin = '0;
  logic [31:0] sec_count = '0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        key_erase, scramble_erase, backup_erase, tamper_irq;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tamper_guard dut_i (
    .clk(clk), .rst_n(rst_n), .tamper_pin(tamper_pin), .sec_count(sec_count),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .key_erase(key_erase), .scramble_erase(scramble_erase),
    .backup_erase(backup_erase), .tamper_irq(tamper_irq)
  );

  // {count, any, exp_bkp, exp_key, bkp_en, key_en, pins, enable}
  localparam logic [23:0] VEC [5] = '{
    {3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01, 8'hFF},
    {3'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h90, 8'hFF},
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'hF0, 8'h0F},
    {3'd2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0E, 8'h0C},
    {3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl(input logic [7:0] en, input logic k, input logic b,
                                        input logic wl, input logic rl);
    return {4'b0, rl, wl, b, k, 16'b0, en};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    chk("reset strobes R2 R3 R4", {29'b0, key_erase, scramble_erase, backup_erase}, 32'd0);
    chk("reset irq R7", {31'b0, tamper_irq}, 32'd0);
    rd(5'd1, d); chk("reset status R7", d, 32'd0);
    rd(5'd3, d); chk("reset log empty R11", d, 32'd0);
    rd(5'd16, d); chk("reset backup R4", d, 32'd0);

    for (int k = 0; k < 5; k++) begin
      logic [7:0] en, pins, act;
      logic [31:0] pat;
      en = VEC[k][7:0]; pins = VEC[k][15:8]; act = en & pins;
      pat = 32'hA5A5_0000 + 32'(k);
      tamper_pin = '0;
      repeat (5) @(negedge clk);
      wr(5'd1, 32'd1);
      wr(5'd0, ctrl(en, VEC[k][16], VEC[k][17], 1'b0, 1'b0));
      wr(5'd16, pat);
      sec_count = 32'd1000 + 32'(k);
      @(negedge clk); tamper_pin = pins;
      repeat (3) @(negedge clk);
      chk("R1 no strobe before detection", {29'b0, key_erase, scramble_erase, backup_erase}, 32'd0);
      @(negedge clk);
      chk("R2 key strobe", {31'b0, key_erase}, {31'b0, VEC[k][18]});
      chk("R3 scramble strobe", {31'b0, scramble_erase}, {31'b0, VEC[k][20]});
      chk("R4 backup strobe", {31'b0, backup_erase}, {31'b0, VEC[k][19]});
      @(negedge clk);
      chk("R3 single pulse", {31'b0, scramble_erase}, 32'd0);
      repeat (10) @(negedge clk);
      rd(5'd16, d); chk("R4 backup content", d, VEC[k][19] ? 32'd0 : pat);
      rd(5'd1, d);
      chk("R7 sticky flag", {31'b0, d[0]}, {31'b0, VEC[k][20]});
      chk("R7 source mask", {24'b0, d[15:8]}, {24'b0, act});
      chk("R1 one entry per pin R5", {28'b0, d[7:4]}, {29'b0, VEC[k][23:21]});
      chk("R7 irq", {31'b0, tamper_irq}, {31'b0, VEC[k][20]});
      for (int i = 0; i < 8; i++) begin
        if (act[i]) begin
          rd(5'd3, d); chk("R6 ascending pin index", d, 32'h8000_0000 | 32'(i));
          rd(5'd2, d); chk("R5 timestamp", d, 32'd1000 + 32'(k));
          wr(5'd3, 32'd0);
        end
      end
      rd(5'd3, d); chk("R11 log drained", d, 32'd0);
      tamper_pin = '0;
    end

    // R7 write-one-to-clear
    wr(5'd1, 32'd1);
    rd(5'd1, d); chk("R7 status cleared", d, 32'd0);
    chk("R7 irq cleared", {31'b0, tamper_irq}, 32'd0);

    // R1 single-period glitch is rejected
    repeat (4) @(negedge clk);
    wr(5'd0, ctrl(8'hFF, 1'b1, 1'b1, 1'b0, 1'b0));
    begin
      int seen_pulse;
      seen_pulse = 0;
      @(negedge clk); tamper_pin = 8'h01;
      @(negedge clk); tamper_pin = 8'h00;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (scramble_erase) seen_pulse++;
      end
      chk("R1 glitch no strobe", 32'(seen_pulse), 32'd0);
    end
    rd(5'd1, d); chk("R1 glitch no status", d, 32'd0);

    // R10 overflow: six pins at once, four newest kept
    sec_count = 32'd77;
    wr(5'd0, ctrl(8'hFF, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk); tamper_pin = 8'h3F;
    repeat (14) @(negedge clk);
    rd(5'd1, d);
    chk("R10 overflow flag", {31'b0, d[1]}, 32'd1);
    chk("R10 log full", {28'b0, d[7:4]}, 32'd4);
    for (int i = 2; i < 6; i++) begin
      rd(5'd3, d); chk("R10 oldest discarded", d, 32'h8000_0000 | 32'(i));
      wr(5'd3, 32'd0);
    end
    rd(5'd3, d); chk("R11 empty after pops", d, 32'd0);
    tamper_pin = '0;
    wr(5'd1, 32'd1);
    rd(5'd1, d); chk("R10 overflow cleared", d, 32'd0);

    // R9 write lock, R8 read lock
    wr(5'd0, ctrl(8'h00, 1'b0, 1'b0, 1'b0, 1'b0));
    wr(5'd17, 32'h0000_1234);
    wr(5'd0, ctrl(8'h00, 1'b0, 1'b0, 1'b1, 1'b0));
    wr(5'd17, 32'hFFFF_FFFF);
    rd(5'd17, d); chk("R9 locked write ignored", d, 32'h0000_1234);
    wr(5'd0, ctrl(8'h00, 1'b0, 1'b0, 1'b0, 1'b1));
    rd(5'd17, d); chk("R8 locked read zero", d, 32'd0);
    wr(5'd0, ctrl(8'h00, 1'b0, 1'b0, 1'b0, 1'b0));
    rd(5'd17, d); chk("R8 unlocked read value", d, 32'h0000_1234);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule